// File: doc/BRIEF.md
# Sample Stream Demultiplexer with Decimating Debug Mode

This block accepts one converter sample per clock, each a `DATA_W`-bit word with an overrange flag. It distributes the samples over two output ports, primary and auxiliary. Two mode pins pick one of three arrangements:
- **Full rate:** every sample goes to the primary port.
- **Half rate:** consecutive samples are paired, and each port updates every second clock.
- **Quarter rate (debug):** alternate samples are thrown away and the kept ones are paired, so each port updates every fourth clock.

A one-clock data-ready strobe marks every port update. A single overrange output merges the flags of the samples being presented.

Samples are handled in groups of 1, 2 or 4 clocks, depending on the mode. A phase counter restarts at each group boundary. The mode pins are only acted on at those boundaries and during reset, so a group never mixes two modes. Latency is counted in whole clocks. `PRI_LAT` sets how long a sample takes to reach the primary port.

Top module: `sample_demux`

## Requirements
- R1: Mode decode. With `demux_en` low the block runs at full rate whatever `div_sel` holds. With `demux_en` high and `div_sel` low it runs at half rate. With both high it runs at quarter rate.
- R2: Full rate. Each sample appears on `pri_data`, `dready` is high in every cycle of steady operation, and `aux_data` reads zero.
- R3: Half rate. In a group of two samples (phase 0, phase 1), `aux_data` shows the phase-0 sample and `pri_data` the phase-1 sample, updated together once per group.
- R4: Quarter rate. In a group of four samples (phases 0 to 3), `aux_data` shows the phase-0 sample and `pri_data` the phase-2 sample. The phase-1 and phase-3 samples are discarded, and the ports update once per group.
- R5: Latency. A sample present at the inputs in cycle c shows on `pri_data` in cycle c+`PRI_LAT`. The auxiliary sample of a pair shares the update, so its latency is one clock longer at half rate and two clocks longer at quarter rate. `PRI_LAT` must be at least 2.
- R6: Overrange merge. At full rate `ovr_out` equals the flag of the primary sample. At half and quarter rate it is the OR of the flags of the two presented samples. The flags of discarded samples have no effect.
- R7: `dready` is high for exactly one clock per port update. Between strobes, `pri_data`, `aux_data` and `ovr_out` hold their values.
- R8: While `rst` is high at a clock edge, the outputs become zero and `dready` low. The first input cycle after reset is phase 0, in the mode the pins gave at the last reset edge.
- R9: The mode pins are sampled only in the last cycle of a group (and at reset). The new mode starts with phase 0 of the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| demux_en | input | 1 | Enables pairing onto two ports |
| div_sel | input | 1 | Selects quarter-rate decimation when pairing is enabled |
| smp_data | input | DATA_W | Incoming sample |
| smp_ovr | input | 1 | Overrange flag of the incoming sample |
| pri_data | output | DATA_W | Primary port (newer sample of a pair) |
| aux_data | output | DATA_W | Auxiliary port (older sample of a pair) |
| ovr_out | output | 1 | Merged overrange flag of the presented samples |
| dready | output | 1 | One-clock strobe on each port update |

## Verification
The bench resets into every mode and changes to every mode at several offsets inside a group. A design that switched modes mid-group would emit a pair built from the wrong phases, and the pair check catches it. At full rate `div_sel` toggles on every sample, which catches a decoder that lets it leak. Overrange flags are placed on discarded quarter-rate samples, where a merge that looked at them would raise `ovr_out` falsely. An off-by-one pipeline shows up as strobes one cycle early or late, and a design that reloaded the ports without a strobe fails the hold comparison made in every cycle.

// File: rtl/sample_demux_pkg.sv
package sample_demux_pkg;

  localparam int PH_W = 2;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_HALF    = 2'd1,
    MODE_QUARTER = 2'd2
  } demux_mode_e;

  // R1: pin decode; div_sel only matters when pairing is enabled
  function automatic demux_mode_e decode_mode(input logic en, input logic sel);
    if (!en)     return MODE_FULL;
    else if (sel) return MODE_QUARTER;
    else         return MODE_HALF;
  endfunction

  function automatic logic [PH_W-1:0] last_phase(input demux_mode_e m);
    case (m)
      MODE_HALF:    return 2'd1;
      MODE_QUARTER: return 2'd3;
      default:      return 2'd0;
    endcase
  endfunction

  // phase in which the sample bound for the primary port arrives
  function automatic logic [PH_W-1:0] pri_phase(input demux_mode_e m);
    case (m)
      MODE_HALF:    return 2'd1;
      MODE_QUARTER: return 2'd2;
      default:      return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sample_demux_ctrl.sv
module sample_demux_ctrl
  import sample_demux_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            demux_en,
  input  logic            div_sel,
  output demux_mode_e     mode,
  output logic [PH_W-1:0] phase,
  output logic            at_last
);

  demux_mode_e     mode_q;
  logic [PH_W-1:0] phase_q;

  assign at_last = (phase_q == last_phase(mode_q));

  // R9: pins are taken only at reset or on the last phase of a group
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= decode_mode(demux_en, div_sel);
      phase_q <= '0;
    end else if (at_last) begin
      mode_q  <= decode_mode(demux_en, div_sel);
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + {{(PH_W-1){1'b0}}, 1'b1};
    end
  end

  assign mode  = mode_q;
  assign phase = phase_q;

endmodule

// File: rtl/sample_demux_steer.sv
module sample_demux_steer
  import sample_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  demux_mode_e       mode,
  input  logic [PH_W-1:0]   phase,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_ovr,
  output logic              grp_vld,
  output logic              grp_ovr,
  output logic [DATA_W-1:0] grp_aux,
  output logic [DATA_W-1:0] grp_pri
);

  logic [DATA_W-1:0] aux_hold;
  logic              aux_ovr_hold;
  logic              paired;

  assign paired = (mode != MODE_FULL);

  // older sample of a pair is parked until its partner arrives
  always_ff @(posedge clk) begin
    if (paired && phase == '0) begin
      aux_hold     <= smp_data;
      aux_ovr_hold <= smp_ovr;
    end
  end

  // one register: the assembled group, flagged when complete
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_vld <= 1'b0;
      grp_ovr <= 1'b0;
      grp_aux <= '0;
      grp_pri <= '0;
    end else begin
      grp_vld <= (phase == pri_phase(mode));
      grp_pri <= smp_data;
      grp_aux <= paired ? aux_hold : '0;
      // R6: merge only the two presented flags; dropped phases never reach here
      grp_ovr <= paired ? (aux_ovr_hold | smp_ovr) : smp_ovr;
    end
  end

endmodule

// File: rtl/sample_demux_align.sv
module sample_demux_align #(
  parameter int DATA_W  = 8,
  parameter int PRI_LAT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_vld,
  input  logic              grp_ovr,
  input  logic [DATA_W-1:0] grp_aux,
  input  logic [DATA_W-1:0] grp_pri,
  output logic              dready,
  output logic              ovr_out,
  output logic [DATA_W-1:0] aux_data,
  output logic [DATA_W-1:0] pri_data
);

  // steer stage and output stage account for two of the PRI_LAT registers
  localparam int SHIFT_N = PRI_LAT - 2;
  localparam int PW      = 2 * DATA_W + 1;

  logic [PW-1:0] head_d;
  logic [PW-1:0] tail_d;
  logic          tail_v;

  assign head_d = {grp_ovr, grp_aux, grp_pri};

  generate
    if (SHIFT_N > 0) begin : g_shift
      logic [SHIFT_N-1:0] vpipe;
      logic [PW-1:0]      dpipe [SHIFT_N];

      // valid bits are reset; data is not, so it can map to shift primitives
      always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[SHIFT_N-1:0], grp_vld} >> 0;
      end

      always_ff @(posedge clk) begin
        dpipe[0] <= head_d;
        for (int i = 1; i < SHIFT_N; i++) dpipe[i] <= dpipe[i-1];
      end

      assign tail_v = vpipe[SHIFT_N-1];
      assign tail_d = dpipe[SHIFT_N-1];
    end else begin : g_direct
      assign tail_v = grp_vld;
      assign tail_d = head_d;
    end
  endgenerate

  // R7: output registers load only with the strobe, otherwise hold
  always_ff @(posedge clk) begin
    if (rst) begin
      dready   <= 1'b0;
      ovr_out  <= 1'b0;
      aux_data <= '0;
      pri_data <= '0;
    end else begin
      dready <= tail_v;
      if (tail_v) {ovr_out, aux_data, pri_data} <= tail_d;
    end
  end

endmodule

// File: rtl/sample_demux.sv
module sample_demux
  import sample_demux_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRI_LAT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              demux_en,
  input  logic              div_sel,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_ovr,
  output logic [DATA_W-1:0] pri_data,
  output logic [DATA_W-1:0] aux_data,
  output logic              ovr_out,
  output logic              dready
);

  demux_mode_e       mode_w;
  logic [PH_W-1:0]   phase_w;
  logic              at_last_w;
  logic              grp_vld, grp_ovr;
  logic [DATA_W-1:0] grp_aux, grp_pri;

  sample_demux_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .demux_en (demux_en),
    .div_sel  (div_sel),
    .mode     (mode_w),
    .phase    (phase_w),
    .at_last  (at_last_w)
  );

  sample_demux_steer #(.DATA_W(DATA_W)) u_steer (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_w),
    .phase    (phase_w),
    .smp_data (smp_data),
    .smp_ovr  (smp_ovr),
    .grp_vld  (grp_vld),
    .grp_ovr  (grp_ovr),
    .grp_aux  (grp_aux),
    .grp_pri  (grp_pri)
  );

  sample_demux_align #(.DATA_W(DATA_W), .PRI_LAT(PRI_LAT)) u_align (
    .clk      (clk),
    .rst      (rst),
    .grp_vld  (grp_vld),
    .grp_ovr  (grp_ovr),
    .grp_aux  (grp_aux),
    .grp_pri  (grp_pri),
    .dready   (dready),
    .ovr_out  (ovr_out),
    .aux_data (aux_data),
    .pri_data (pri_data)
  );

endmodule

// File: rtl/sample_demux_chk.sv
module sample_demux_chk
  import sample_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] pri_data,
  input logic [DATA_W-1:0] aux_data,
  input logic              ovr_out,
  input logic              dready,
  input demux_mode_e       mode,
  input logic [PH_W-1:0]   phase,
  input logic              at_last
);

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!dready && pri_data == '0 && aux_data == '0 && !ovr_out));

  assert_hold_between_strobes_R7: assert property (@(posedge clk) disable iff (rst)
    (!dready && !$past(rst)) |-> ($stable(pri_data) && $stable(aux_data) && $stable(ovr_out)));

  assert_mode_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    ((mode != $past(mode)) && !$past(rst)) |-> $past(at_last));

  assert_phase_in_group_R4: assert property (@(posedge clk) disable iff (rst)
    phase <= last_phase(mode));

endmodule

bind sample_demux sample_demux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pri_data (pri_data),
  .aux_data (aux_data),
  .ovr_out  (ovr_out),
  .dready   (dready),
  .mode     (mode_w),
  .phase    (phase_w),
  .at_last  (at_last_w)
);

// File: tb/tb_sample_demux.sv
`timescale 1ns/1ps
module tb_sample_demux;

  localparam int W     = 8;
  localparam int LAT   = 8;
  localparam int DEPTH = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic         sel = 1'b0;
  logic [W-1:0] sdat = '0;
  logic         sovr = 1'b0;
  logic [W-1:0] pri_data, aux_data;
  logic         ovr_out, dready;

  sample_demux #(.DATA_W(W), .PRI_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .demux_en(en), .div_sel(sel),
    .smp_data(sdat), .smp_ovr(sovr),
    .pri_data(pri_data), .aux_data(aux_data), .ovr_out(ovr_out), .dready(dready)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int g = 0;
  int mode_b = 0;
  int phase_b = 0;
  logic [W-1:0] hold_aux;
  logic         hold_ovr;
  logic         ev_v   [DEPTH];
  logic [W-1:0] ev_aux [DEPTH];
  logic [W-1:0] ev_pri [DEPTH];
  logic         ev_ovr [DEPTH];
  int           ev_mode[DEPTH];
  logic [W-1:0] cur_aux, cur_pri;
  logic         cur_ovr;

  // model of R1 decode: 0 full, 1 half, 2 quarter
  function automatic int dec(input logic e, input logic s);
    return !e ? 0 : (s ? 2 : 1);
  endfunction
  function automatic int lastp(input int m);
    return m == 0 ? 0 : (m == 1 ? 1 : 3);
  endfunction
  function automatic int prip(input int m);
    return m == 0 ? 0 : (m == 1 ? 1 : 2);
  endfunction
  function automatic string tagof(input int m);
    return m == 0 ? "R2 R1" : (m == 1 ? "R3 R9" : "R4 R9");
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d act=%0h exp=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic set_pins(input int m);
    en  = (m != 0);
    sel = (m == 2) || (m == 0 && (g % 2) == 1);
  endtask

  // R8: reset into mode m, outputs must be zero while it is held
  task automatic do_reset(input int m);
    @(negedge clk);
    rst = 1'b1;
    set_pins(m);
    repeat (3) begin
      @(negedge clk);
      chk(dready == 1'b0, "R8", "dready in reset", dready, 0);
      chk(pri_data == '0 && aux_data == '0 && !ovr_out, "R8", "ports in reset",
          {ovr_out, aux_data, pri_data}, 0);
    end
    for (int i = 0; i < DEPTH; i++) ev_v[i] = 1'b0;
    cyc = 0; mode_b = m; phase_b = 0;
    cur_aux = '0; cur_pri = '0; cur_ovr = 1'b0;
  endtask

  // one cycle: check outputs of this cycle, then drive its inputs
  task automatic step(input int m);
    int idx;
    int j;
    string tag;
    idx = cyc % DEPTH;
    // R5 strobe timing and R7 single pulse per update
    chk(dready === ev_v[idx], "R5 R7", "dready", dready, ev_v[idx]);
    if (ev_v[idx]) begin
      cur_aux = ev_aux[idx]; cur_pri = ev_pri[idx]; cur_ovr = ev_ovr[idx];
      tag = tagof(ev_mode[idx]);
    end else begin
      tag = "R7";
    end
    chk(pri_data === cur_pri, tag, "pri_data", pri_data, cur_pri);
    chk(aux_data === cur_aux, tag, "aux_data", aux_data, cur_aux);
    chk(ovr_out === cur_ovr, ev_v[idx] ? "R6" : "R7", "ovr_out", ovr_out, cur_ovr);
    ev_v[idx] = 1'b0;

    rst = 1'b0;
    set_pins(m);
    sdat = W'((g * 73 + 11) & 'hFF);
    sovr = ((g % 3) == 1) ^ ((g % 7) == 0);
    g++;

    if (mode_b != 0 && phase_b == 0) begin
      hold_aux = sdat; hold_ovr = sovr;
    end
    if (phase_b == prip(mode_b)) begin
      j = (cyc + LAT) % DEPTH;
      ev_v[j]    = 1'b1;
      ev_pri[j]  = sdat;
      ev_aux[j]  = (mode_b == 0) ? '0 : hold_aux;
      ev_ovr[j]  = (mode_b == 0) ? sovr : (hold_ovr | sovr);
      ev_mode[j] = mode_b;
    end
    if (phase_b == lastp(mode_b)) begin
      mode_b = dec(en, sel);
      phase_b = 0;
    end else begin
      phase_b++;
    end
    cyc++;
  endtask

  initial begin
    // R1: full rate with div_sel toggling every sample
    do_reset(0);
    for (int k = 0; k < 40; k++) begin @(negedge clk); step(0); end
    // sweep every mode pair, switching at varied group offsets (R9)
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        do_reset(a);
        for (int k = 0; k < 10 + a + b; k++) begin @(negedge clk); step(a); end
        for (int k = 0; k < 24; k++) begin @(negedge clk); step(b); end
        for (int k = 0; k < LAT + 4; k++) begin @(negedge clk); step(b); end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule